// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This unit runs the per-processor side of interrupt handling: it takes an interrupt when a processor acknowledges it, and it retires the interrupt when the processor signals end-of-interrupt (EOI). Each processor has its own running interrupt ID and running priority. An acknowledge accepts the highest pending ID only if that ID is more urgent than the work the processor is already doing. The accepted ID then preempts the current work, and the preempted ID is remembered.

Preempted interrupts are kept per processor as a linked chain indexed by interrupt ID. Each accepted ID stores the ID it preempted. Completion therefore does not have to follow nesting order. Retiring the running ID restores its predecessor. Retiring an ID deeper in the chain unlinks it: a small state machine walks the chain for a few cycles, and new requests are held off while it does so.

The pending, trigger, level, enable, target and priority state belongs to the surrounding distributor. This unit reads that state through ports and sends pending-clear and pending-set pulses back to it.

Top module: `iack_unit`

## Requirements
- R1: An acknowledge responds one cycle later on `ack_rsp_id`. The response is 1023 when the highest pending ID of that processor is 1023, or when that ID's priority is not strictly below the processor's running priority. Otherwise the response is the pending ID.
- R2: A granted acknowledge produces one pending-clear pulse for the granted ID. The mask covers every processor when the source's `src_one_of_n` bit is 1; otherwise it has only bit `req_cpu` set.
- R3: A granted ID becomes the processor's running ID, and its 8-bit priority, zero-extended, becomes the running priority. Whenever the running ID is 1023, the running priority is 0x100.
- R4: An EOI whose ID is NUM_SRC or above, the spurious ID 1023 included, changes nothing.
- R5: An EOI arriving while the processor's running ID is 1023 changes nothing and raises no pending-set pulse.
- R6: An accepted EOI for a source that is enabled, has its level input high, has its edge bit clear and has its target bit set for this processor raises one pending-set pulse for that ID. The mask has only bit `req_cpu` set.
- R7: An EOI for the running ID makes the ID that it preempted the running ID again, or 1023 if it preempted nothing.
- R8: An EOI for an ID deeper in the chain leaves the running ID unchanged and removes that ID from the chain. Later completions skip it. The walk takes at most NUM_SRC cycles with `busy` high.
- R9: Only bits [9:0] of `eoi_data` form the EOI ID.
- R10: While `busy` is high, acknowledge and EOI requests are ignored. No response and no state change result from them.
- R11: After reset every running ID is 1023, every running priority is 0x100, and `busy` and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_ack | input | 1 | Acknowledge request strobe |
| req_eoi | input | 1 | End-of-interrupt request strobe |
| req_cpu | input | CPU_W | Processor issuing the request |
| eoi_data | input | 32 | EOI write value; low 10 bits are the ID |
| hp_id_flat | input | NUM_CPU*10 | Highest pending ID per processor |
| src_prio_flat | input | NUM_SRC*PRIO_W | Priority per source |
| src_one_of_n | input | NUM_SRC | Source uses the 1-of-N model |
| src_edge | input | NUM_SRC | Source is edge triggered |
| src_level | input | NUM_SRC | Current level of source input |
| src_enable | input | NUM_SRC | Source enabled |
| src_target_flat | input | NUM_SRC*NUM_CPU | Target processor bits per source |
| busy | output | 1 | Chain walk in progress |
| ack_rsp_valid | output | 1 | Acknowledge response valid |
| ack_rsp_id | output | 10 | Acknowledge response ID |
| pend_clr_valid | output | 1 | Pending-clear pulse |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_mask | output | NUM_CPU | Processors to clear |
| pend_set_valid | output | 1 | Pending-set pulse |
| pend_set_id | output | 10 | ID to set |
| pend_set_mask | output | NUM_CPU | Processors to set |
| run_id_flat | output | NUM_CPU*10 | Running ID per processor |
| run_prio_flat | output | NUM_CPU*(PRIO_W+1) | Running priority per processor |

## Verification
The assertions take several things for granted about the inputs:
- `req_ack` and `req_eoi` are never high in the same cycle.
- `hp_id_flat` holds either an ID below NUM_SRC or 1023.
- Interrupt priorities stay fixed while an ID is on a chain.

The stimulus keeps to this. It raises one strobe per cycle and picks pending IDs only from implemented sources or 1023. It holds the priority table constant, with priority equal to four times the ID. The bench asserts one request while `busy` is high, on purpose, to show that the request is ignored.

// File: rtl/iack_pkg.sv
// Shared constants and types for the acknowledge/completion unit.
// Assumes interrupt IDs are 10 bits wide, with 1023 meaning "none".
package iack_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_t;
endpackage

// File: rtl/iack_link_store.sv
// Per-processor predecessor links, one entry per interrupt source.
// Entry [c][s] holds the ID that source s preempted on processor c.
// There is one write port and two combinational read ports. The caller
// keeps its indices below NUM_SRC whenever it uses the data that is read.
module iack_link_store
    import iack_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_SRC = 64,
    parameter int CPU_W   = 1,
    parameter int SRC_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [SRC_W-1:0] wr_idx,
    input  logic [ID_W-1:0]  wr_data,
    input  logic [CPU_W-1:0] rd_cpu,
    input  logic [SRC_W-1:0] rd_idx_a,
    output logic [ID_W-1:0]  rd_data_a,
    input  logic [SRC_W-1:0] rd_idx_b,
    output logic [ID_W-1:0]  rd_data_b
);
    logic [ID_W-1:0] links [NUM_CPU][NUM_SRC];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            // Hold one link entry; cleared to "none" at reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    links[c][s] <= NO_IRQ;
                else if (wr_en && wr_cpu == CPU_W'(c) && wr_idx == SRC_W'(s))
                    links[c][s] <= wr_data;
            end
        end
    end

    assign rd_data_a = links[rd_cpu][rd_idx_a];
    assign rd_data_b = links[rd_cpu][rd_idx_b];
endmodule

// File: rtl/iack_prio_sel.sv
// Looks up the priority of an interrupt ID and widens it by one bit.
// IDs at or above NUM_SRC, "none" included, yield the idle value
// 1 << PRIO_W, which no real priority can reach.
module iack_prio_sel
    import iack_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [ID_W-1:0]           id,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [PRIO_W:0]           prio
);
    localparam int SRC_W = $clog2(NUM_SRC);
    logic [SRC_W-1:0] idx;

    assign idx = SRC_W'(id);

    // Pick the table entry, or the idle value for unimplemented IDs.
    always_comb begin
        if (int'(id) < NUM_SRC)
            prio = {1'b0, prio_flat[int'(idx)*PRIO_W +: PRIO_W]};
        else
            prio = (PRIO_W+1)'(1) << PRIO_W;
    end
endmodule

// File: rtl/iack_unit.sv
// Acknowledge and completion unit for NUM_CPU processors.
// Acknowledge: grants the highest pending ID if it is more urgent than the
// running one, records the preempted ID as its link, and pulses a pending
// clear. EOI: retires an ID; the running ID pops to its link, while a
// nested ID is unlinked by a multi-cycle walk during which busy is high.
// Assumes at most one request strobe per cycle and pending IDs that are
// below NUM_SRC or equal to 1023.
module iack_unit
    import iack_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 8,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_ack,
    input  logic                          req_eoi,
    input  logic [CPU_W-1:0]              req_cpu,
    input  logic [31:0]                   eoi_data,
    input  logic [NUM_CPU*ID_W-1:0]       hp_id_flat,
    input  logic [NUM_SRC*PRIO_W-1:0]     src_prio_flat,
    input  logic [NUM_SRC-1:0]            src_one_of_n,
    input  logic [NUM_SRC-1:0]            src_edge,
    input  logic [NUM_SRC-1:0]            src_level,
    input  logic [NUM_SRC-1:0]            src_enable,
    input  logic [NUM_SRC*NUM_CPU-1:0]    src_target_flat,
    output logic                          busy,
    output logic                          ack_rsp_valid,
    output logic [ID_W-1:0]               ack_rsp_id,
    output logic                          pend_clr_valid,
    output logic [ID_W-1:0]               pend_clr_id,
    output logic [NUM_CPU-1:0]            pend_clr_mask,
    output logic                          pend_set_valid,
    output logic [ID_W-1:0]               pend_set_id,
    output logic [NUM_CPU-1:0]            pend_set_mask,
    output logic [NUM_CPU*ID_W-1:0]       run_id_flat,
    output logic [NUM_CPU*(PRIO_W+1)-1:0] run_prio_flat
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int CNT_W = SRC_W + 1;
    localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1) << PRIO_W;

    walk_state_t      state;
    logic [ID_W-1:0]  run_id   [NUM_CPU];
    logic [PRIO_W:0]  run_prio [NUM_CPU];
    logic [CPU_W-1:0] walk_cpu;
    logic [ID_W-1:0]  walk_tgt;
    logic [ID_W-1:0]  walk_cur;
    logic [CNT_W-1:0] walk_cnt;

    logic             idle;
    logic [ID_W-1:0]  ack_id, eoi_id, cur_run, rd_a, rd_b;
    logic [SRC_W-1:0] ack_idx, eoi_idx;
    logic [PRIO_W:0]  ack_prio, rest_prio;
    logic             ack_ok, eoi_ok, relevel, walk_hit, walk_stop;
    logic [NUM_CPU-1:0] cpu_bit;
    logic             lk_wr_en;
    logic [CPU_W-1:0] lk_wr_cpu, lk_rd_cpu;
    logic [SRC_W-1:0] lk_wr_idx, lk_rd_idx_a;
    logic [ID_W-1:0]  lk_wr_data;
    wire              unused_eoi_hi = ^eoi_data[31:ID_W];

    assign idle    = (state == ST_IDLE);
    assign busy    = !idle;
    assign cur_run = run_id[req_cpu];
    assign ack_id  = hp_id_flat[int'(req_cpu)*ID_W +: ID_W];
    assign ack_idx = SRC_W'(ack_id);
    assign eoi_id  = eoi_data[ID_W-1:0];
    assign eoi_idx = SRC_W'(eoi_id);
    assign cpu_bit = NUM_CPU'(1) << req_cpu;

    iack_prio_sel #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_ack_prio (
        .id(ack_id), .prio_flat(src_prio_flat), .prio(ack_prio));
    iack_prio_sel #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_rest_prio (
        .id(rd_a), .prio_flat(src_prio_flat), .prio(rest_prio));

    // Decide on a grant, an accepted EOI, reassertion and the walk outcome.
    always_comb begin
        ack_ok    = (ack_id != NO_IRQ) && (ack_prio < run_prio[req_cpu]);
        eoi_ok    = (int'(eoi_id) < NUM_SRC) && (cur_run != NO_IRQ);
        relevel   = !src_edge[eoi_idx] && src_enable[eoi_idx] && src_level[eoi_idx]
                    && src_target_flat[int'(eoi_idx)*NUM_CPU + int'(req_cpu)];
        walk_hit  = (rd_a == walk_tgt);
        walk_stop = (rd_a == NO_IRQ) || walk_hit || (walk_cnt == CNT_W'(NUM_SRC-1));
    end

    // Route the link store ports between grant, pop and unlink use.
    always_comb begin
        lk_rd_cpu   = idle ? req_cpu : walk_cpu;
        lk_rd_idx_a = idle ? SRC_W'(cur_run) : SRC_W'(walk_cur);
        lk_wr_en    = idle ? (req_ack && ack_ok) : walk_hit;
        lk_wr_cpu   = lk_rd_cpu;
        lk_wr_idx   = idle ? ack_idx : SRC_W'(walk_cur);
        lk_wr_data  = idle ? cur_run : rd_b;
    end

    iack_link_store #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .CPU_W(CPU_W), .SRC_W(SRC_W)) u_links (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lk_wr_en), .wr_cpu(lk_wr_cpu), .wr_idx(lk_wr_idx), .wr_data(lk_wr_data),
        .rd_cpu(lk_rd_cpu), .rd_idx_a(lk_rd_idx_a), .rd_data_a(rd_a),
        .rd_idx_b(SRC_W'(walk_tgt)), .rd_data_b(rd_b));

    // Sequence grants, completions and the unlink walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            walk_cpu       <= '0;
            walk_tgt       <= NO_IRQ;
            walk_cur       <= NO_IRQ;
            walk_cnt       <= '0;
            ack_rsp_valid  <= 1'b0;
            ack_rsp_id     <= NO_IRQ;
            pend_clr_valid <= 1'b0;
            pend_clr_id    <= NO_IRQ;
            pend_clr_mask  <= '0;
            pend_set_valid <= 1'b0;
            pend_set_id    <= NO_IRQ;
            pend_set_mask  <= '0;
            for (int c = 0; c < NUM_CPU; c++) begin
                run_id[c]   <= NO_IRQ;
                run_prio[c] <= IDLE_PRIO;
            end
        end else begin
            ack_rsp_valid  <= 1'b0;
            pend_clr_valid <= 1'b0;
            pend_set_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_ack) begin
                        ack_rsp_valid <= 1'b1;
                        ack_rsp_id    <= ack_ok ? ack_id : NO_IRQ;
                        if (ack_ok) begin
                            run_id[req_cpu]   <= ack_id;
                            run_prio[req_cpu] <= ack_prio;
                            pend_clr_valid    <= 1'b1;
                            pend_clr_id       <= ack_id;
                            pend_clr_mask     <= src_one_of_n[ack_idx] ? '1 : cpu_bit;
                        end
                    end else if (req_eoi && eoi_ok) begin
                        if (relevel) begin
                            pend_set_valid <= 1'b1;
                            pend_set_id    <= eoi_id;
                            pend_set_mask  <= cpu_bit;
                        end
                        if (eoi_id == cur_run) begin
                            run_id[req_cpu]   <= rd_a;
                            run_prio[req_cpu] <= rest_prio;
                        end else begin
                            state    <= ST_WALK;
                            walk_cpu <= req_cpu;
                            walk_tgt <= eoi_id;
                            walk_cur <= cur_run;
                            walk_cnt <= '0;
                        end
                    end
                end
                ST_WALK: begin
                    if (walk_stop) begin
                        state <= ST_IDLE;
                    end else begin
                        walk_cur <= rd_a;
                        walk_cnt <= walk_cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_out
        assign run_id_flat[c*ID_W +: ID_W]             = run_id[c];
        assign run_prio_flat[c*(PRIO_W+1) +: PRIO_W+1] = run_prio[c];
    end
endmodule

// File: rtl/iack_unit_chk.sv
// Checker for iack_unit, attached by bind. Observes ports only and
// assumes a single request strobe per cycle.
module iack_unit_chk
    import iack_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_ack,
    input logic                          req_eoi,
    input logic [31:0]                   eoi_data,
    input logic                          busy,
    input logic                          ack_rsp_valid,
    input logic [ID_W-1:0]               ack_rsp_id,
    input logic                          pend_clr_valid,
    input logic                          pend_set_valid,
    input logic [NUM_CPU-1:0]            pend_set_mask,
    input logic [NUM_CPU*ID_W-1:0]       run_id_flat,
    input logic [NUM_CPU*(PRIO_W+1)-1:0] run_prio_flat
);
    localparam int BW = $clog2(NUM_SRC + 2) + 1;
    logic [BW-1:0] busy_run;

    // Count consecutive busy cycles to bound the walk length.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + BW'(1);
        else           busy_run <= '0;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
            run_id_flat[c*ID_W +: ID_W] == NO_IRQ |->
            run_prio_flat[c*(PRIO_W+1) +: PRIO_W+1] == ((PRIO_W+1)'(1) << PRIO_W)); // R3
    end

    AST_RSP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rsp_valid |-> $past(req_ack && !busy)); // R1
    AST_SPURIOUS_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rsp_valid && ack_rsp_id == NO_IRQ |-> !pend_clr_valid); // R1
    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rsp_valid && ack_rsp_id != NO_IRQ |-> pend_clr_valid); // R2
    AST_HIGH_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        req_eoi && !req_ack && !busy && int'(eoi_data[ID_W-1:0]) >= NUM_SRC
        |=> !pend_set_valid && !busy && $stable(run_id_flat)); // R4
    AST_SET_ONE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set_valid |-> $countones(pend_set_mask) == 1); // R6
    AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(busy_run) <= NUM_SRC); // R8
    AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (req_ack || req_eoi) |=> !ack_rsp_valid && !pend_clr_valid); // R10
endmodule

bind iack_unit iack_unit_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .req_eoi(req_eoi),
    .eoi_data(eoi_data), .busy(busy), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_id(ack_rsp_id), .pend_clr_valid(pend_clr_valid),
    .pend_set_valid(pend_set_valid), .pend_set_mask(pend_set_mask),
    .run_id_flat(run_id_flat), .run_prio_flat(run_prio_flat));

// File: tb/iack_unit_tb_top.sv
// Bench for iack_unit: a vector table of acknowledge/EOI operations,
// then directed tests for masks, reassertion, masking and the stalled walk.
module iack_unit_tb_top;
    localparam int NC = 2;
    localparam int NS = 64;
    localparam int PW = 8;
    localparam int NONE = 1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_ack = 1'b0, req_eoi = 1'b0;
    logic [0:0] req_cpu = '0;
    logic [31:0] eoi_data = '0;
    logic [NC*10-1:0] hp_id_flat = {NC{10'd1023}};
    logic [NS*PW-1:0] src_prio_flat;
    logic [NS-1:0] src_one_of_n, src_edge, src_level, src_enable;
    logic [NS*NC-1:0] src_target_flat;
    logic busy, ack_rsp_valid, pend_clr_valid, pend_set_valid;
    logic [9:0] ack_rsp_id, pend_clr_id, pend_set_id;
    logic [NC-1:0] pend_clr_mask, pend_set_mask;
    logic [NC*10-1:0] run_id_flat;
    logic [NC*(PW+1)-1:0] run_prio_flat;

    int checks = 0, fails = 0;
    logic s_rsp_v, s_clr_v, s_set_v;
    int s_rsp_id, s_clr_id, s_clr_mask, s_set_id, s_set_mask;

    always #10 clk = ~clk;

    iack_unit #(.NUM_CPU(NC), .NUM_SRC(NS), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .req_eoi(req_eoi),
        .req_cpu(req_cpu), .eoi_data(eoi_data), .hp_id_flat(hp_id_flat),
        .src_prio_flat(src_prio_flat), .src_one_of_n(src_one_of_n),
        .src_edge(src_edge), .src_level(src_level), .src_enable(src_enable),
        .src_target_flat(src_target_flat), .busy(busy),
        .ack_rsp_valid(ack_rsp_valid), .ack_rsp_id(ack_rsp_id),
        .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id),
        .pend_clr_mask(pend_clr_mask), .pend_set_valid(pend_set_valid),
        .pend_set_id(pend_set_id), .pend_set_mask(pend_set_mask),
        .run_id_flat(run_id_flat), .run_prio_flat(run_prio_flat));

    // Source configuration: priority = 4*id; 7 is 1-of-N; 30,31,33 level
    // triggered; 30 and 33 asserted; 33 targets processor 0 only.
    initial begin
        for (int s = 0; s < NS; s++) begin
            src_prio_flat[s*PW +: PW] = PW'(s * 4);
            src_target_flat[s*NC +: NC] = 2'b11;
        end
        src_target_flat[33*NC +: NC] = 2'b01;
        src_one_of_n = '0; src_one_of_n[7] = 1'b1;
        src_edge = '1; src_edge[30] = 1'b0; src_edge[31] = 1'b0; src_edge[33] = 1'b0;
        src_level = '0; src_level[30] = 1'b1; src_level[33] = 1'b1;
        src_enable = '1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int run_of(input int cpu);
        return int'(run_id_flat[cpu*10 +: 10]);
    endfunction

    function automatic int prio_of(input int cpu);
        return int'(run_prio_flat[cpu*(PW+1) +: PW+1]);
    endfunction

    // One request; capture the registered results, then wait out any walk.
    task automatic apply(input bit is_eoi, input int cpu, input int val);
        @(negedge clk);
        req_cpu = cpu[0:0];
        if (is_eoi) begin eoi_data = val; req_eoi = 1'b1; end
        else begin hp_id_flat[cpu*10 +: 10] = val[9:0]; req_ack = 1'b1; end
        @(negedge clk);
        req_ack = 1'b0; req_eoi = 1'b0;
        s_rsp_v = ack_rsp_valid; s_rsp_id = int'(ack_rsp_id);
        s_clr_v = pend_clr_valid; s_clr_id = int'(pend_clr_id); s_clr_mask = int'(pend_clr_mask);
        s_set_v = pend_set_valid; s_set_id = int'(pend_set_id); s_set_mask = int'(pend_set_mask);
        while (busy) @(negedge clk);
    endtask

    // {is_eoi, cpu, id, expected response, expected running ID after}
    localparam int NV = 17;
    localparam logic [31:0] VECS [NV] = '{
        {1'b0, 1'b0, 10'd20,   10'd20,   10'd20},
        {1'b0, 1'b0, 10'd10,   10'd10,   10'd10},
        {1'b0, 1'b0, 10'd30,   10'd1023, 10'd10},
        {1'b0, 1'b0, 10'd5,    10'd5,    10'd5},
        {1'b1, 1'b0, 10'd10,   10'd0,    10'd5},
        {1'b1, 1'b0, 10'd5,    10'd0,    10'd20},
        {1'b1, 1'b0, 10'd20,   10'd0,    10'd1023},
        {1'b1, 1'b0, 10'd20,   10'd0,    10'd1023},
        {1'b0, 1'b1, 10'd1023, 10'd1023, 10'd1023},
        {1'b0, 1'b1, 10'd40,   10'd40,   10'd40},
        {1'b1, 1'b1, 10'd1023, 10'd0,    10'd40},
        {1'b1, 1'b1, 10'd63,   10'd0,    10'd40},
        {1'b1, 1'b1, 10'd100,  10'd0,    10'd40},
        {1'b1, 1'b1, 10'd40,   10'd0,    10'd1023},
        {1'b0, 1'b0, 10'd20,   10'd20,   10'd20},
        {1'b0, 1'b0, 10'd21,   10'd1023, 10'd20},
        {1'b1, 1'b0, 10'd20,   10'd0,    10'd1023}
    };

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 run0", run_of(0), NONE);
        chk("R11 run1", run_of(1), NONE);
        chk("R11 prio0", prio_of(0), 256);
        chk("R11 busy", int'(busy), 0);
        chk("R11 rsp_valid", int'(ack_rsp_valid), 0);

        for (int v = 0; v < NV; v++) begin
            automatic logic [31:0] w = VECS[v];
            apply(w[31], int'(w[30]), int'(w[29:20]));
            if (!w[31]) begin
                chk($sformatf("R1 vec%0d rsp_valid", v), int'(s_rsp_v), 1);
                chk($sformatf("R1 vec%0d rsp_id", v), s_rsp_id, int'(w[19:10]));
                chk($sformatf("R3 vec%0d running", v), run_of(int'(w[30])), int'(w[9:0]));
            end else begin
                chk($sformatf("R4/R7/R8 vec%0d running", v), run_of(int'(w[30])), int'(w[9:0]));
            end
        end

        // R2 pending-clear masks
        apply(1'b0, 0, 7);
        chk("R2 clr id 1-of-N", s_clr_id, 7);
        chk("R2 clr mask 1-of-N", s_clr_mask, 3);
        apply(1'b1, 0, 7);
        apply(1'b0, 0, 8);
        chk("R2 clr mask N-N cpu0", s_clr_mask, 1);
        apply(1'b1, 0, 8);
        apply(1'b0, 1, 9);
        chk("R2 clr mask N-N cpu1", s_clr_mask, 2);
        apply(1'b1, 1, 9);

        // R3 running priority and R6 reassertion of level sources
        apply(1'b0, 1, 30);
        chk("R3 run prio", prio_of(1), 120);
        apply(1'b1, 1, 30);
        chk("R6 set valid", int'(s_set_v), 1);
        chk("R6 set id", s_set_id, 30);
        chk("R6 set mask", s_set_mask, 2);
        chk("R3 prio idle", prio_of(1), 256);
        apply(1'b0, 1, 31);
        apply(1'b1, 1, 31);
        chk("R6 level low no set", int'(s_set_v), 0);
        apply(1'b0, 1, 33);
        apply(1'b1, 1, 33);
        chk("R6 untargeted no set", int'(s_set_v), 0);

        // R5 EOI while nothing runs
        apply(1'b1, 0, 30);
        chk("R5 idle eoi no set", int'(s_set_v), 0);
        chk("R5 idle eoi running", run_of(0), NONE);

        // R9 only low 10 bits of the EOI value count
        apply(1'b0, 0, 22);
        apply(1'b1, 0, 32'h0000_7C16);
        chk("R9 masked eoi", run_of(0), NONE);

        // R8 deep unlink with R10 stall during the walk
        apply(1'b0, 0, 40);
        apply(1'b0, 0, 20);
        apply(1'b0, 0, 10);
        apply(1'b0, 0, 5);
        @(negedge clk);
        req_cpu = 1'b0; eoi_data = 40; req_eoi = 1'b1;
        @(negedge clk);
        req_eoi = 1'b0;
        chk("R8 walk busy", int'(busy), 1);
        hp_id_flat[9:0] = 10'd1; req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        chk("R10 no rsp while busy", int'(ack_rsp_valid), 0);
        while (busy) @(negedge clk);
        chk("R10 running kept", run_of(0), 5);
        apply(1'b1, 0, 5);
        chk("R7 pop to 10", run_of(0), 10);
        apply(1'b1, 0, 10);
        chk("R7 pop to 20", run_of(0), 20);
        apply(1'b1, 0, 20);
        chk("R8 unlinked 40 skipped", run_of(0), NONE);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule